// File: doc/BRIEF.md
# Three-Bit Synchronous Down Counter Built from JK Cells

This block steps a three-bit binary value downward, one count per rising clock edge: 7, 6, 5, 4, 3, 2, 1, 0, and then back to 7. The cycle repeats for as long as the clock runs. All state bits share a single clock, so every bit that changes does so on the same edge.

The state is not produced by an arithmetic subtract. Each bit is held in its own behavioural JK flip-flop cell. A combinational stage derives that cell's J and K inputs from the present state alone, using equations taken from the JK excitation table. Both the J and K values are brought out to the ports so they can be observed.

The three state bits can feed the low inputs of a seven-segment digit decoder, so a display would show 7 down to 0 and then repeat. A synchronous active-high reset loads 7, the first value of the sequence.

Top module: `jk_down_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge of `clk`, the count is loaded with 3'b111 and holds there for as long as `rst` stays high.
- R2: With `rst` low, every rising edge replaces the count with (count − 1) modulo 8, with bit 2 as the MSB.
- R3: From 3'b000, the next rising edge with `rst` low gives 3'b111.
- R4: Bit 0's J and K inputs (`j_out[0]`, `k_out[0]`) are both 1 at all times, so bit 0 toggles on every edge.
- R5: Bit 1's J and K inputs both equal the inverse of count bit 0.
- R6: Bit 2's J and K inputs both equal 1 exactly when count bits 1 and 0 are both 0.
- R7: Each state bit follows the JK function table at every edge. J=0,K=0 holds the bit, J=0,K=1 clears it, J=1,K=0 sets it, and J=1,K=1 inverts it.
- R8: The count changes only at rising edges and stays steady across the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by every flip-flop cell; the state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset that loads 3'b111 |
| count | output | 3 | Present state, bit 2 most significant |
| j_out | output | 3 | J input currently applied to each cell, indexed by bit |
| k_out | output | 3 | K input currently applied to each cell, indexed by bit |

## Verification
The bound checker evaluates the following on every cycle:
- the reset load,
- the modulo-8 step,
- the wrap from 0 to 7,
- the J/K equations for each bit,
- the JK function table, applied to each bit from the previous cycle's inputs.

Some behaviours can only be shown by the bench's scenarios:
- the full ordered walk through two complete cycles, compared against a decrement computed in the bench;
- a reset that arrives in the middle of a count, and the count holding through several edges while reset stays high;
- the count staying steady between a rising edge and the following falling edge.

// File: rtl/jk_counter_pkg.sv
package jk_counter_pkg;

    // Drive applied to one JK cell
    typedef struct packed {
        logic j;
        logic k;
    } jk_drive_t;

    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_INVERT = 2'b11
    } jk_action_e;

    function automatic jk_action_e jk_decode(input jk_drive_t d);
        return jk_action_e'({d.j, d.k});
    endfunction

    // Next value of one cell under the JK function table
    function automatic logic jk_apply(input logic q, input jk_drive_t d);
        case (jk_decode(d))
            JK_HOLD:   return q;
            JK_CLEAR:  return 1'b0;
            JK_SET:    return 1'b1;
            default:   return ~q;
        endcase
    endfunction

endpackage

// File: rtl/jk_cell.sv
module jk_cell
    import jk_counter_pkg::*;
#(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  jk_drive_t drive,
    output logic      q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else begin
            q <= jk_apply(q, drive);
        end
    end

endmodule

// File: rtl/jk_drive_logic.sv
module jk_drive_logic
    import jk_counter_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0]            state,
    output jk_drive_t [WIDTH-1:0]       drive
);

    // Excitation-table result for a down count: a bit must move only when
    // every lower bit is 0. Both J and K are 1 then (0->1 needs J=1, 1->0
    // needs K=1). Otherwise both are 0 (0->0 needs J=0, 1->1 needs K=0).
    // The don't-care entries are resolved equal to the other input.
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            if (b == 0) begin : g_lsb
                assign drive[b].j = 1'b1;
                assign drive[b].k = 1'b1;
            end else begin : g_upper
                logic lower_clear;
                assign lower_clear = ~|state[b-1:0];
                assign drive[b].j  = lower_clear;
                assign drive[b].k  = lower_clear;
            end
        end
    endgenerate

endmodule

// File: rtl/jk_down_counter.sv
module jk_down_counter
    import jk_counter_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] j_out,
    output logic [WIDTH-1:0] k_out
);

    jk_drive_t [WIDTH-1:0] drive;

    jk_drive_logic #(.WIDTH(WIDTH)) u_drive (
        .state (count),
        .drive (drive)
    );

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_cell
            jk_cell #(.RESET_VAL(1'b1)) u_cell (
                .clk   (clk),
                .rst   (rst),
                .drive (drive[b]),
                .q     (count[b])
            );
            assign j_out[b] = drive[b].j;
            assign k_out[b] = drive[b].k;
        end
    endgenerate

endmodule

// File: rtl/jk_down_counter_checker.sv
module jk_down_counter_checker #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] j_out,
    input logic [WIDTH-1:0] k_out
);

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> count == {WIDTH{1'b1}});

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) - WIDTH'(1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        count == '0 |=> count == {WIDTH{1'b1}});

    assert_lsb_drive_R4: assert property (@(posedge clk) disable iff (rst)
        j_out[0] && k_out[0]);

    assert_bit1_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (j_out[1] == !count[0]) && (k_out[1] == !count[0]));

    assert_bit2_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (j_out[2] == (count[1:0] == 2'b00)) && (k_out[2] == j_out[2]));

    assert_jk_table_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == (($past(j_out) & ~$past(count)) |
                           (~$past(k_out) & $past(count))));

endmodule

bind jk_down_counter jk_down_counter_checker #(.WIDTH(WIDTH)) u_checker (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .j_out (j_out),
    .k_out (k_out)
);

// File: tb/jk_down_counter_test.sv
`timescale 1ns/1ps
module jk_down_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] count, j_out, k_out;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #5 clk = ~clk;

    jk_down_counter uut (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .j_out (j_out),
        .k_out (k_out)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Expected J/K for present state s, computed from the stated equations
    task automatic check_drive(input logic [2:0] s);
        logic [2:0] e;
        e = {~s[1] & ~s[0], ~s[0], 1'b1};
        check("R4 bit0 J", {2'b0, j_out[0]}, {2'b0, e[0]});
        check("R4 bit0 K", {2'b0, k_out[0]}, {2'b0, e[0]});
        check("R5 bit1 J/K", {1'b0, j_out[1], k_out[1]}, {1'b0, e[1], e[1]});
        check("R6 bit2 J/K", {1'b0, j_out[2], k_out[2]}, {1'b0, e[2], e[2]});
    endtask

    task automatic test_reset_hold;
        @(negedge clk); rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset load/hold", count, 3'b111);
        end
    endtask

    task automatic test_two_cycles;
        logic [2:0] exp;
        logic [2:0] prev;
        exp = 3'b111;
        @(negedge clk); rst = 1'b0;
        check("R1 value before first step", count, 3'b111);
        for (int i = 0; i < 17; i++) begin
            check_drive(count);
            prev = count;
            @(negedge clk);
            exp = exp - 3'd1;
            if (prev == 3'b000) check("R3 wrap to 7", count, 3'b111);
            check("R2 step down", count, exp);
            // JK table per bit, from the drive observed before the edge
            check("R7 JK table", count,
                  ({~prev[1] & ~prev[0], ~prev[0], 1'b1} & ~prev) |
                  (~{~prev[1] & ~prev[0], ~prev[0], 1'b1} & prev));
        end
    endtask

    task automatic test_mid_reset;
        @(negedge clk); @(negedge clk);
        check("R2 mid count before reset", count, 3'b100);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-count reset", count, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        check("R2 first step after reset", count, 3'b110);
    endtask

    task automatic test_edge_only;
        logic [2:0] after_rise;
        @(posedge clk); #1 after_rise = count;
        @(negedge clk); #1
        check("R8 steady across falling edge", count, after_rise);
        @(posedge clk); #1
        check("R8 changes at rising edge", count, after_rise - 3'd1);
    endtask

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset_hold();
        test_two_cycles();   // leaves count at 3'b110
        test_mid_reset();
        test_edge_only();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule